// File: doc/BRIEF.md
# Split Counter with Test Isolation

This block is a wide up-counter assembled from equal narrow segments (by default two 8-bit segments forming a 16-bit count). In functional operation the segments form one carry chain, so the block behaves as a single binary counter that advances once per cycle in which `count_en` is high. Checking every state of such a counter end to end takes one clock per state, which for 16 bits is 65536 cycles.

Raising `test_mode` cuts the carry chain between segments. The lowest segment keeps counting on `count_en`, but its wrap no longer reaches the segment above it. Each upper segment instead advances on its own tester step strobe and can be preset from a tester data bus. The lowest segment's value is brought out on a dedicated observation port. With the chain cut, each 8-bit segment can be walked through all of its states on its own. Done one after the other, the two segments need 512 cycles. Done together, they need 256 cycles.

The tester clock is modelled as a synchronous step strobe that is qualified on the block's single clock. No second clock domain is introduced.

Top module: `pcnt_top`

## Requirements
- R1: While `rst_n` is low, `cnt_q` is all zeros and `obs_q` is zero. Both remain at zero in the first cycle after reset is released.
- R2: With `test_mode` low, each rising clock edge on which `count_en` is high adds one to `cnt_q`, modulo 2^(SEG_W*NUM_SEG). When `count_en` is low, `cnt_q` holds its value.
- R3: With `test_mode` low, an upper segment advances only on an edge where `count_en` is high and every segment below it holds its maximum value. An all-ones count returns to zero.
- R4: With `test_mode` low, `tst_step`, `tst_load` and `tst_data` have no effect on `cnt_q`.
- R5: With `test_mode` high, the low segment (`cnt_q[SEG_W-1:0]`) advances on `count_en` and wraps from all-ones to zero. Its wrap leaves the upper segments unchanged.
- R6: With `test_mode` high, upper segment k (`cnt_q[(k+1)*SEG_W-1:k*SEG_W]`) advances by one on each edge where `tst_step[k-1]` is high, whatever the value of `count_en`. When its strobe is low it holds its value.
- R7: With `test_mode` high, `tst_load[k-1]` high loads upper segment k from `tst_data[k*SEG_W-1:(k-1)*SEG_W]` on the next edge. Loading takes priority over `tst_step[k-1]`.
- R8: `obs_q` equals the low segment while `test_mode` is high and is zero while `test_mode` is low. It follows `test_mode` in the same cycle.
- R9: With `test_mode` high, the low segment and upper segments can advance on the same edge. 256 such edges return both 8-bit segments to their starting values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | High cuts the carry chain and hands upper segments to the tester |
| count_en | input | 1 | Functional count enable |
| tst_step | input | NUM_SEG-1 | Tester step strobe, one per upper segment |
| tst_load | input | NUM_SEG-1 | Tester preset strobe, one per upper segment |
| tst_data | input | SEG_W*(NUM_SEG-1) | Tester preset values, segment 1 in the lowest bits |
| cnt_q | output | SEG_W*NUM_SEG | Full counter value |
| obs_q | output | SEG_W | Observation of the low segment (zero outside test mode) |

## Verification
The bench counts the low segment up to 255 and then one step further, to show that the carry lands in the high segment in normal mode. It repeats the same wrap in test mode, where a leaking carry would move the high byte. It presets the high byte to 0xFF and counts up to 0xFFFF, then checks that one more functional step gives zero. A design with a broken top carry would stop at 0xFF00 or hold the value instead. It drives `tst_load` and `tst_step` in the same cycle, where getting the priority wrong shows as the loaded value plus one. It drives the tester inputs in normal mode, where a missing gate changes the count. It runs 256 parallel steps, which must leave both halves back where they began.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

   typedef enum logic {
      MODE_FUNC = 1'b0,
      MODE_TEST = 1'b1
   } pcnt_mode_e;

   function automatic pcnt_mode_e to_mode(input logic tm);
      return tm ? MODE_TEST : MODE_FUNC;
   endfunction

endpackage

// File: rtl/pcnt_seg.sv
module pcnt_seg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] q_o,
   output logic         max_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pcnt_seg: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_r <= '0;
      else if (load_i)
         q_r <= load_val_i;
      else if (inc_i)
         q_r <= q_r + 1'b1;
   end

   assign q_o   = q_r;
   assign max_o = &q_r;
endmodule

// File: rtl/pcnt_link.sv
module pcnt_link
   import pcnt_pkg::*;
#(
   parameter int SEG_W   = 8,
   parameter int NUM_SEG = 2,
   localparam int UPR   = NUM_SEG - 1,
   localparam int TST_W = SEG_W * UPR
) (
   input  logic               test_mode,
   input  logic               count_en,
   input  logic [NUM_SEG-1:0] seg_max,
   input  logic [UPR-1:0]     tst_step,
   input  logic [UPR-1:0]     tst_load,
   input  logic [TST_W-1:0]   tst_data,
   output logic [NUM_SEG-1:0] seg_inc,
   output logic [NUM_SEG-1:0] seg_load,
   output logic [SEG_W*NUM_SEG-1:0] seg_val
);
   pcnt_mode_e   mode;
   logic [NUM_SEG-1:0] carry;

   assign mode     = to_mode(test_mode);
   assign carry[0] = count_en;

   // The low segment always runs on the functional enable and is never preset.
   assign seg_inc[0]          = count_en;
   assign seg_load[0]         = 1'b0;
   assign seg_val[SEG_W-1:0]  = '0;

   generate
      for (genvar k = 1; k < NUM_SEG; k++) begin : g_upper
         logic data_pass;
         // Ripple carry: segment k sees a carry when all lower segments are full.
         assign carry[k] = carry[k-1] & seg_max[k-1];
         // Data inhibit: the carry is blocked while in test mode.
         assign data_pass = (mode == MODE_FUNC) & carry[k];
         // Clock select: the functional carry or the tester step.
         assign seg_inc[k]  = (mode == MODE_TEST) ? tst_step[k-1] : data_pass;
         assign seg_load[k] = (mode == MODE_TEST) & tst_load[k-1];
         assign seg_val[(k+1)*SEG_W-1:k*SEG_W] = tst_data[k*SEG_W-1:(k-1)*SEG_W];
      end
   endgenerate
endmodule

// File: rtl/pcnt_obs.sv
module pcnt_obs
   import pcnt_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         test_mode,
   input  logic [W-1:0] seg_q,
   output logic [W-1:0] obs_q
);
   always_comb begin
      if (to_mode(test_mode) == MODE_TEST)
         obs_q = seg_q;
      else
         obs_q = '0;
   end
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top #(
   parameter int SEG_W   = 8,
   parameter int NUM_SEG = 2,
   localparam int CNT_W  = SEG_W * NUM_SEG,
   localparam int TST_W  = SEG_W * (NUM_SEG - 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               test_mode,
   input  logic               count_en,
   input  logic [NUM_SEG-2:0] tst_step,
   input  logic [NUM_SEG-2:0] tst_load,
   input  logic [TST_W-1:0]   tst_data,
   output logic [CNT_W-1:0]   cnt_q,
   output logic [SEG_W-1:0]   obs_q
);
   generate
      if (NUM_SEG < 2) begin : g_bad_seg
         $error("pcnt_top: NUM_SEG must be at least 2");
      end
      if (SEG_W < 1) begin : g_bad_w
         $error("pcnt_top: SEG_W must be at least 1");
      end
   endgenerate

   logic [NUM_SEG-1:0] seg_max;
   logic [NUM_SEG-1:0] seg_inc;
   logic [NUM_SEG-1:0] seg_load;
   logic [CNT_W-1:0]   seg_val;

   pcnt_link #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_link (
      .test_mode (test_mode),
      .count_en  (count_en),
      .seg_max   (seg_max),
      .tst_step  (tst_step),
      .tst_load  (tst_load),
      .tst_data  (tst_data),
      .seg_inc   (seg_inc),
      .seg_load  (seg_load),
      .seg_val   (seg_val)
   );

   generate
      for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
         pcnt_seg #(.W(SEG_W)) u_seg (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      (seg_inc[s]),
            .load_i     (seg_load[s]),
            .load_val_i (seg_val[(s+1)*SEG_W-1:s*SEG_W]),
            .q_o        (cnt_q[(s+1)*SEG_W-1:s*SEG_W]),
            .max_o      (seg_max[s])
         );
      end
   endgenerate

   pcnt_obs #(.W(SEG_W)) u_obs (
      .test_mode (test_mode),
      .seg_q     (cnt_q[SEG_W-1:0]),
      .obs_q     (obs_q)
   );
endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk #(
   parameter int SEG_W   = 8,
   parameter int NUM_SEG = 2,
   localparam int CNT_W  = SEG_W * NUM_SEG,
   localparam int TST_W  = SEG_W * (NUM_SEG - 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               test_mode,
   input logic               count_en,
   input logic [NUM_SEG-2:0] tst_step,
   input logic [NUM_SEG-2:0] tst_load,
   input logic [TST_W-1:0]   tst_data,
   input logic [CNT_W-1:0]   cnt_q,
   input logic [SEG_W-1:0]   obs_q
);
   logic [SEG_W-1:0] lo_q;
   logic [SEG_W-1:0] s1_q;
   assign lo_q = cnt_q[SEG_W-1:0];
   assign s1_q = cnt_q[2*SEG_W-1:SEG_W];

   // R2: functional increment
   a_r2_func_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && count_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R2 and R4: functional hold, with tester inputs ignored
   a_r4_func_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !count_en) |=> $stable(cnt_q));

   // R5: in test mode, segment 1 is untouched without a tester strobe
   a_r5_seg1_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !tst_step[0] && !tst_load[0]) |=> $stable(s1_q));

   // R5: in test mode, the low segment follows count_en
   a_r5_lo_step: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && count_en) |=> (lo_q == $past(lo_q) + 1'b1));

   // R6: tester step advances segment 1
   a_r6_seg1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && tst_step[0] && !tst_load[0]) |=> (s1_q == $past(s1_q) + 1'b1));

   // R7: tester load wins over step
   a_r7_seg1_load: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && tst_load[0]) |=> (s1_q == $past(tst_data[SEG_W-1:0])));

   // R8: observation port
   a_r8_obs_test: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> (obs_q == lo_q));
   a_r8_obs_func: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> (obs_q == '0));
endmodule

bind pcnt_top pcnt_chk #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .test_mode (test_mode),
   .count_en  (count_en),
   .tst_step  (tst_step),
   .tst_load  (tst_load),
   .tst_data  (tst_data),
   .cnt_q     (cnt_q),
   .obs_q     (obs_q)
);

// File: tb/pcnt_top_tb.sv
module pcnt_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        test_mode = 1'b0;
   logic        count_en = 1'b0;
   logic [0:0]  tst_step = 1'b0;
   logic [0:0]  tst_load = 1'b0;
   logic [7:0]  tst_data = 8'h00;
   logic [15:0] cnt_q;
   logic [7:0]  obs_q;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pcnt_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_mode (test_mode),
      .count_en  (count_en),
      .tst_step  (tst_step),
      .tst_load  (tst_load),
      .tst_data  (tst_data),
      .cnt_q     (cnt_q),
      .obs_q     (obs_q)
   );

   typedef struct packed {
      logic        tm;
      logic        en;
      logic        st;
      logic        ld;
      logic [7:0]  d;
      logic [15:0] exp_cnt;
      logic [7:0]  exp_obs;
      logic [3:0]  req;
   } vec_t;

   // Walked from a freshly reset counter (value 0).
   localparam vec_t VEC [0:11] = '{
      '{1'b0,1'b1,1'b0,1'b0,8'h00,16'h0001,8'h00,4'd2}, // R2 step
      '{1'b0,1'b0,1'b0,1'b0,8'h00,16'h0001,8'h00,4'd2}, // R2 hold
      '{1'b0,1'b1,1'b1,1'b1,8'hAA,16'h0002,8'h00,4'd4}, // R4 tester ignored
      '{1'b1,1'b1,1'b0,1'b0,8'h00,16'h0003,8'h03,4'd5}, // R5 low alone
      '{1'b1,1'b0,1'b1,1'b0,8'h00,16'h0103,8'h03,4'd6}, // R6 high step
      '{1'b1,1'b0,1'b1,1'b1,8'h5A,16'h5A03,8'h03,4'd7}, // R7 load wins
      '{1'b1,1'b1,1'b1,1'b0,8'h00,16'h5B04,8'h04,4'd9}, // R9 both
      '{1'b1,1'b0,1'b0,1'b0,8'h00,16'h5B04,8'h04,4'd6}, // R6 hold
      '{1'b0,1'b1,1'b0,1'b0,8'h00,16'h5B05,8'h00,4'd8}, // R8 obs zero
      '{1'b1,1'b1,1'b0,1'b1,8'hFF,16'hFF06,8'h06,4'd7}, // R7 load plus low step
      '{1'b0,1'b0,1'b0,1'b1,8'h12,16'hFF06,8'h00,4'd4}, // R4 load ignored
      '{1'b0,1'b1,1'b0,1'b0,8'h00,16'hFF07,8'h00,4'd2}  // R2 step
   };

   task automatic check(input string tag, input logic [15:0] ec, input logic [7:0] eo);
      n_run++;
      if (cnt_q !== ec || obs_q !== eo) begin
         n_fail++;
         $display("FAIL %s: cnt_q=%h obs_q=%h expected cnt_q=%h obs_q=%h",
                  tag, cnt_q, obs_q, ec, eo);
      end
   endtask

   // Apply one cycle of stimulus; outputs are settled 2 ns after the edge.
   task automatic cyc(input logic tm, input logic en, input logic st,
                      input logic ld, input logic [7:0] d);
      test_mode = tm; count_en = en; tst_step = st; tst_load = ld; tst_data = d;
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1 in reset", 16'h0000, 8'h00);
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R1 after release", 16'h0000, 8'h00);

      foreach (VEC[i]) begin
         cyc(VEC[i].tm, VEC[i].en, VEC[i].st, VEC[i].ld, VEC[i].d);
         n_run++;
         if (cnt_q !== VEC[i].exp_cnt || obs_q !== VEC[i].exp_obs) begin
            n_fail++;
            $display("FAIL R%0d vector %0d: cnt_q=%h obs_q=%h expected cnt_q=%h obs_q=%h",
                     VEC[i].req, i, cnt_q, obs_q, VEC[i].exp_cnt, VEC[i].exp_obs);
         end
      end

      // R1: reset mid-run clears the count
      test_mode = 1'b0; count_en = 1'b0;
      rst_n = 1'b0;
      #3;
      check("R1 mid-run reset", 16'h0000, 8'h00);
      @(posedge clk); #2;
      rst_n = 1'b1;

      // R3: carry into the high half
      for (int i = 0; i < 255; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R3 before carry", 16'h00FF, 8'h00);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R3 carry", 16'h0100, 8'h00);

      // R5: low wrap in test mode leaves the high half alone
      for (int i = 0; i < 255; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R5 low at max", 16'h01FF, 8'hFF);
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R5 low wrap isolated", 16'h0100, 8'h00);

      // R9: 256 parallel steps
      for (int i = 0; i < 255; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
      check("R9 parallel 255", 16'h00FF, 8'hFF);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
      check("R9 parallel 256", 16'h0100, 8'h00);

      // R3: all-ones wraps to zero
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
      check("R7 preset FF", 16'hFF00, 8'h00);
      for (int i = 0; i < 255; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R5 reach FFFF", 16'hFFFF, 8'hFF);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R8 obs drops", 16'hFFFF, 8'h00);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      check("R3 full wrap", 16'h0000, 8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule